// File: doc/BRIEF.md
# SPI Engine Interrupt and Status Register Block

This block is the software-visible control face of a FIFO-based SPI engine. It decodes a simple 32-bit register port and offers an identification word, a hold control for the engine core, an interrupt mask, a set of write-one-to-clear pending flags, a live view of the raw interrupt conditions, the identifier of the most recent synchronisation point the core has reached, and free-space and fill readouts for the engine's three FIFOs. The command, transmit and receive FIFOs and the SPI execution core live outside the block. The block receives their occupancy counts and a synchronisation strobe, and it drives a reset for the core and one interrupt line.

Three of the four interrupt sources are derived from levels. The command and transmit FIFOs raise their flag while their occupancy is at or below a low-water parameter. The receive FIFO raises its flag while its fill is at or above a high-water parameter. These flags are set again on every cycle the condition persists, so clearing one while its condition is still true has no effect. The fourth source is an event: a one-cycle strobe from the core captures an 8-bit progress identifier and latches its pending flag until software clears it. A driver uses this flag to learn that a queued command sequence has finished.

Register offsets (byte addresses on the 8-bit address port): 0x00 identification, 0x40 core hold, 0x80 mask, 0x84 pending, 0x88 raw conditions, 0xC0 last sync identifier, 0xD0 command FIFO free space, 0xD4 transmit FIFO free space, 0xD8 receive FIFO fill. Interrupt bit positions, shared by mask, pending and raw registers, are: bit 0 command low-water, bit 1 transmit low-water, bit 2 receive high-water, bit 3 sync event.

Top module: `spe_ctl_regs`

## Requirements
- R1: A read of offset 0x00 returns 0x01 in bits [23:16], parameter VER_MINOR in bits [15:8], parameter VER_PATCH in bits [7:0] and zero in bits [31:24].
- R2: The core hold output `core_rst` is 1 after reset. A write to 0x40 loads it from write-data bit 0, and a read of 0x40 returns it in bit 0. No other write changes it.
- R3: A write to 0x80 loads the 4-bit interrupt mask from write-data bits [3:0]. A read of 0x80 returns the mask zero-extended, and the mask is 0 after reset.
- R4: A read of 0x88 returns the raw conditions. Bit 0 is (command occupancy <= CMD_LOW_TH), bit 1 is (transmit occupancy <= SDO_LOW_TH), bit 2 is (receive occupancy >= SDI_HIGH_TH) and bit 3 is the current value of `sync_stb`.
- R5: Pending bits [2:0] become 1 on every clock edge at which their condition from R4 holds. A write to 0x84 clears each pending bit whose write-data bit is 1, so a write of 0xFF clears all four. Pending is 0 after reset.
- R6: A clock edge with `sync_stb` high stores `sync_id` into the register read at 0xC0 (bits [7:0]) and sets pending bit 3.
- R7: When a clear of a pending bit and a set of the same bit happen at the same clock edge, the bit ends up 1.
- R8: `irq` is 1 exactly when some bit is 1 both in pending and in the mask.
- R9: Reads of 0xD0 and 0xD4 return the FIFO depth minus the command and transmit occupancy respectively. A read of 0xD8 returns the receive occupancy.
- R10: Writes to read-only or unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| reg_we | input | 1 | Register write strobe, one write per cycle it is high |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_occ | input | $clog2(CMD_DEPTH+1) | Command FIFO occupancy |
| sdo_occ | input | $clog2(SDO_DEPTH+1) | Transmit FIFO occupancy |
| sdi_occ | input | $clog2(SDI_DEPTH+1) | Receive FIFO occupancy |
| sync_stb | input | 1 | One-cycle sync event from the engine core |
| sync_id | input | 8 | Progress identifier carried with the sync event |
| core_rst | output | 1 | Hold for the engine core, active high |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with all three FIFO depths set to 4, low-water thresholds of 1 and a high-water threshold of 3. It also sets VER_MINOR to 2 and VER_PATCH to 0x61. With these values every combination of the three occupancies (125 of them) can be swept. For each one the bench checks the free-space and fill readouts, the raw condition word, the re-assertion of pending bits after a full clear, and the interrupt line under a mask. Both sides of each threshold and the empty and full extremes are therefore covered. Directed sequences then cover the sync capture, the case where a clear and a sync event happen in the same cycle, the masking, the core hold and writes to read-only offsets.

// File: rtl/spe_ctl_pkg.sv
package spe_ctl_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IRQ_N  = 4;

  localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_HOLD  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_SYNC  = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_CROOM = 8'hD0;
  localparam logic [ADDR_W-1:0] OFS_TROOM = 8'hD4;
  localparam logic [ADDR_W-1:0] OFS_RFILL = 8'hD8;

  localparam int IB_CMD_LOW  = 0;
  localparam int IB_SDO_LOW  = 1;
  localparam int IB_SDI_HIGH = 2;
  localparam int IB_SYNC     = 3;

  localparam logic [7:0] IDENT_MAJOR = 8'h01;
endpackage

// File: rtl/spe_lvl_cmp.sv
module spe_lvl_cmp #(
  parameter int W     = 5,
  parameter int TH    = 4,
  parameter bit ABOVE = 1'b0
) (
  input  logic [W-1:0] occ,
  output logic         hit
);
  localparam logic [W-1:0] TH_W = W'(TH);

  generate
    if (ABOVE) begin : g_high
      assign hit = (occ >= TH_W);
    end else begin : g_low
      assign hit = (occ <= TH_W);
    end
  endgenerate
endmodule

// File: rtl/spe_irq_ctl.sv
module spe_irq_ctl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         pend_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] pend_d;
  logic [N-1:0] clr_vec;
  logic         pend_en;

  always_comb begin
    clr_vec = pend_we ? wbits : '0;
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    pend_en = pend_we | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wbits;
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/spe_rd_mux.sv
module spe_rd_mux
  import spe_ctl_pkg::*;
#(
  parameter int         CW        = 5,
  parameter int         TW        = 5,
  parameter int         RW        = 5,
  parameter int         CMD_DEPTH = 16,
  parameter int         SDO_DEPTH = 16,
  parameter logic [7:0] VER_MINOR = 8'h00,
  parameter logic [7:0] VER_PATCH = 8'h61
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold_q,
  input  logic [IRQ_N-1:0]  mask_q,
  input  logic [IRQ_N-1:0]  pend_q,
  input  logic [IRQ_N-1:0]  raw_vec,
  input  logic [7:0]        sync_q,
  input  logic [CW-1:0]     cmd_occ,
  input  logic [TW-1:0]     sdo_occ,
  input  logic [RW-1:0]     sdi_occ,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CW-1:0] CDEP = CW'(CMD_DEPTH);
  localparam logic [TW-1:0] TDEP = TW'(SDO_DEPTH);

  logic [CW-1:0] croom;
  logic [TW-1:0] troom;

  assign croom = CDEP - cmd_occ;
  assign troom = TDEP - sdo_occ;

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_IDENT: rdata = {8'h00, IDENT_MAJOR, VER_MINOR, VER_PATCH};
      OFS_HOLD:  rdata = DATA_W'(hold_q);
      OFS_MASK:  rdata = DATA_W'(mask_q);
      OFS_PEND:  rdata = DATA_W'(pend_q);
      OFS_RAW:   rdata = DATA_W'(raw_vec);
      OFS_SYNC:  rdata = DATA_W'(sync_q);
      OFS_CROOM: rdata = DATA_W'(croom);
      OFS_TROOM: rdata = DATA_W'(troom);
      OFS_RFILL: rdata = DATA_W'(sdi_occ);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/spe_ctl_regs.sv
module spe_ctl_regs
  import spe_ctl_pkg::*;
#(
  parameter int         CMD_DEPTH   = 16,
  parameter int         SDO_DEPTH   = 16,
  parameter int         SDI_DEPTH   = 16,
  parameter int         CMD_LOW_TH  = 4,
  parameter int         SDO_LOW_TH  = 4,
  parameter int         SDI_HIGH_TH = 12,
  parameter logic [7:0] VER_MINOR   = 8'h00,
  parameter logic [7:0] VER_PATCH   = 8'h61,
  localparam int        CW = $clog2(CMD_DEPTH + 1),
  localparam int        TW = $clog2(SDO_DEPTH + 1),
  localparam int        RW = $clog2(SDI_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CW-1:0]     cmd_occ,
  input  logic [TW-1:0]     sdo_occ,
  input  logic [RW-1:0]     sdi_occ,
  input  logic              sync_stb,
  input  logic [7:0]        sync_id,
  output logic              core_rst,
  output logic              irq
);
  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // write decode
  logic we_hold, we_mask, we_pend;
  assign we_hold = reg_we && (reg_addr == OFS_HOLD);
  assign we_mask = reg_we && (reg_addr == OFS_MASK);
  assign we_pend = reg_we && (reg_addr == OFS_PEND);

  // raw interrupt conditions
  logic [IRQ_N-1:0] raw_vec;

  spe_lvl_cmp #(.W(CW), .TH(CMD_LOW_TH), .ABOVE(1'b0)) u_cmd_low (
    .occ(cmd_occ), .hit(raw_vec[IB_CMD_LOW])
  );
  spe_lvl_cmp #(.W(TW), .TH(SDO_LOW_TH), .ABOVE(1'b0)) u_sdo_low (
    .occ(sdo_occ), .hit(raw_vec[IB_SDO_LOW])
  );
  spe_lvl_cmp #(.W(RW), .TH(SDI_HIGH_TH), .ABOVE(1'b1)) u_sdi_high (
    .occ(sdi_occ), .hit(raw_vec[IB_SDI_HIGH])
  );
  assign raw_vec[IB_SYNC] = sync_stb;

  // pending / mask / interrupt
  logic [IRQ_N-1:0] pend_q;
  logic [IRQ_N-1:0] mask_q;

  spe_irq_ctl #(.N(IRQ_N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .mask_we (we_mask),
    .pend_we (we_pend),
    .wbits   (reg_wdata[IRQ_N-1:0]),
    .set_vec (raw_vec),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  // core hold register
  logic hold_q, hold_d;
  always_comb hold_d = reg_wdata[0];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     hold_q <= 1'b1;
    else if (we_hold) hold_q <= hold_d;
  end
  assign core_rst = hold_q;

  // sync identifier capture
  logic [7:0] sync_q, sync_d;
  always_comb sync_d = sync_id;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      sync_q <= 8'h00;
    else if (sync_stb) sync_q <= sync_d;
  end

  spe_rd_mux #(
    .CW(CW), .TW(TW), .RW(RW),
    .CMD_DEPTH(CMD_DEPTH), .SDO_DEPTH(SDO_DEPTH),
    .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_rd (
    .addr    (reg_addr),
    .hold_q  (hold_q),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .raw_vec (raw_vec),
    .sync_q  (sync_q),
    .cmd_occ (cmd_occ),
    .sdo_occ (sdo_occ),
    .sdi_occ (sdi_occ),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/spe_ctl_chk.sv
module spe_ctl_chk
  import spe_ctl_pkg::*;
#(
  parameter int CW         = 5,
  parameter int CMD_LOW_TH = 4
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CW-1:0]     cmd_occ,
  input logic              sync_stb,
  input logic [7:0]        sync_id,
  input logic [7:0]        sync_q,
  input logic [IRQ_N-1:0]  pend_q,
  input logic [IRQ_N-1:0]  mask_q,
  input logic              core_rst,
  input logic              irq
);
  logic pend_clr3, pend_clr0, hold_wr, cmd_low;
  assign pend_clr3 = reg_we && (reg_addr == OFS_PEND) && reg_wdata[IB_SYNC];
  assign pend_clr0 = reg_we && (reg_addr == OFS_PEND) && reg_wdata[IB_CMD_LOW];
  assign hold_wr   = reg_we && (reg_addr == OFS_HOLD);
  assign cmd_low   = (cmd_occ <= CW'(CMD_LOW_TH));

  AST_SYNC_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_s_n)
    sync_stb |=> pend_q[IB_SYNC]); // R6
  AST_SYNC_ID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_s_n)
    sync_stb |=> (sync_q == $past(sync_id))); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sync_stb && pend_clr3) |=> pend_q[IB_SYNC]); // R7
  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_low |=> pend_q[IB_CMD_LOW]); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pend_clr0 && !cmd_low) |=> !pend_q[IB_CMD_LOW]); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mask_q == '0) |-> !irq); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !hold_wr |=> $stable(core_rst)); // R2
endmodule

bind spe_ctl_regs spe_ctl_chk #(.CW(CW), .CMD_LOW_TH(CMD_LOW_TH)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_occ(cmd_occ), .sync_stb(sync_stb),
  .sync_id(sync_id), .sync_q(sync_q), .pend_q(pend_q), .mask_q(mask_q),
  .core_rst(core_rst), .irq(irq)
);

// File: tb/sim_spe_ctl_regs.sv
module sim_spe_ctl_regs;
  localparam int D   = 4;
  localparam int LTH = 1;
  localparam int HTH = 3;
  localparam int W   = $clog2(D + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [W-1:0] cmd_occ, sdo_occ, sdi_occ;
  logic        sync_stb;
  logic [7:0]  sync_id;
  logic        core_rst, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  spe_ctl_regs #(
    .CMD_DEPTH(D), .SDO_DEPTH(D), .SDI_DEPTH(D),
    .CMD_LOW_TH(LTH), .SDO_LOW_TH(LTH), .SDI_HIGH_TH(HTH),
    .VER_MINOR(8'h02), .VER_PATCH(8'h61)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_occ(cmd_occ),
    .sdo_occ(sdo_occ), .sdi_occ(sdi_occ), .sync_stb(sync_stb),
    .sync_id(sync_id), .core_rst(core_rst), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_sync(input logic [7:0] id);
    @(negedge clk);
    sync_stb = 1'b1; sync_id = id;
    @(negedge clk);
    sync_stb = 1'b0;
  endtask

  function automatic logic [3:0] cond(input int c, input int t, input int r);
    return {1'b0, (r >= HTH), (t <= LTH), (c <= LTH)};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  cv;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cmd_occ = W'(D); sdo_occ = W'(D); sdi_occ = '0;
    sync_stb = 1'b0; sync_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(8'h40, v); chk("R2 hold after reset", v, 32'h1);
    chk("R2 core_rst pin after reset", {31'b0, core_rst}, 32'h1);
    rd(8'h80, v); chk("R3 mask after reset", v, 32'h0);
    rd(8'h84, v); chk("R5 pending after reset", v, 32'h0);
    chk("R8 irq after reset", {31'b0, irq}, 32'h0);

    rd(8'h00, v); chk("R1 identification", v, 32'h0001_0261);

    // core hold
    wr(8'h40, 32'h0); rd(8'h40, v); chk("R2 hold released", v, 32'h0);
    chk("R2 core_rst released", {31'b0, core_rst}, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF); chk("R2 core_rst held again", {31'b0, core_rst}, 32'h1);
    wr(8'h40, 32'h2); chk("R2 bit1 ignored, bit0 zero releases", {31'b0, core_rst}, 32'h0);

    // mask register
    wr(8'h80, 32'hFFFF_FFF5); rd(8'h80, v); chk("R3 mask readback", v, 32'h5);

    // sweep all occupancies
    wr(8'h80, 32'h7);
    for (int c = 0; c <= D; c++) begin
      for (int t = 0; t <= D; t++) begin
        for (int r = 0; r <= D; r++) begin
          @(negedge clk);
          cmd_occ = W'(c); sdo_occ = W'(t); sdi_occ = W'(r);
          cv = cond(c, t, r);
          rd(8'hD0, v); chk("R9 command free space", v, 32'(D - c));
          rd(8'hD4, v); chk("R9 transmit free space", v, 32'(D - t));
          rd(8'hD8, v); chk("R9 receive fill", v, 32'(r));
          rd(8'h88, v); chk("R4 raw conditions", v, {28'b0, cv});
          wr(8'h84, 32'hFF);
          rd(8'h84, v); chk("R5 pending re-armed after clear", v, {28'b0, cv});
          chk("R8 irq under mask 0x7", {31'b0, irq}, {31'b0, |cv});
        end
      end
    end

    // quiet conditions
    @(negedge clk);
    cmd_occ = W'(D); sdo_occ = W'(D); sdi_occ = '0;
    wr(8'h84, 32'hFF);
    rd(8'h84, v); chk("R5 clear with conditions false", v, 32'h0);
    wr(8'h80, 32'h0);

    // sync event
    pulse_sync(8'hA7);
    rd(8'hC0, v); chk("R6 sync id captured", v, 32'hA7);
    rd(8'h84, v); chk("R6 sync pending set", v, 32'h8);
    chk("R8 masked sync keeps irq low", {31'b0, irq}, 32'h0);
    wr(8'h80, 32'h8);
    chk("R8 unmasked sync raises irq", {31'b0, irq}, 32'h1);
    wr(8'h84, 32'h7);
    rd(8'h84, v); chk("R5 clear of other bits leaves sync", v, 32'h8);
    wr(8'h84, 32'h8);
    rd(8'h84, v); chk("R5 sync pending cleared", v, 32'h0);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);

    // clear and set in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h84; reg_wdata = 32'h8;
    sync_stb = 1'b1; sync_id = 8'h3C;
    @(negedge clk);
    reg_we = 1'b0; sync_stb = 1'b0;
    rd(8'h84, v); chk("R7 set wins over clear", v, 32'h8);
    rd(8'hC0, v); chk("R7 id from simultaneous event", v, 32'h3C);
    chk("R8 irq after simultaneous event", {31'b0, irq}, 32'h1);

    // read-only and unmapped writes
    wr(8'hC0, 32'h55); rd(8'hC0, v); chk("R10 sync id write ignored", v, 32'h3C);
    wr(8'h00, 32'h0);  rd(8'h00, v); chk("R10 identification write ignored", v, 32'h0001_0261);
    wr(8'h44, 32'h0);  chk("R10 unmapped write leaves hold", {31'b0, core_rst}, 32'h0);
    wr(8'h88, 32'hF);  rd(8'h84, v); chk("R10 raw write leaves pending", v, 32'h8);
    rd(8'h44, v); chk("R10 unmapped read zero", v, 32'h0);
    rd(8'hFC, v); chk("R10 unmapped read zero high", v, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule